// File: doc/BRIEF.md
# MSI-X Capability Register Block

This block holds the MSI-X capability structure that a PCI Express function exposes in its configuration space. It decodes configuration reads and writes that carry a dword address and four byte enables, and it answers only when the address falls inside the three dwords of the capability. The capability sits at a byte offset fixed by a parameter. Other parameters set the vector count, the next-capability pointer and the index of the BAR that holds the vector table and the pending array. Those values are reported back as read-only fields.

Software can change only two bits: the global enable and the function mask. The block holds both bits and drives them to the vector dispatcher. Each write byte is filtered on its own, so a write never changes any other field. The block also sends the dispatcher a one-cycle rescan request when a write could have released interrupts that were held pending. This happens when the function mask goes from 1 to 0, or when enable goes from 0 to 1 while the mask stays clear. The dispatcher then looks for pending vectors and delivers them.

Top module: `msix_cap_regs`

## Requirements
- R1: Capability byte 0 reads as the capability ID 0x11 and byte 1 reads as the next-capability pointer parameter. Writes to these bytes have no effect.
- R2: Bits 10:0 of the message control word (bytes 2 and 3 of the first dword) read as the vector count minus 1. Bits 13:11 read as zero.
- R3: Only bit 15 (enable) and bit 14 (function mask) of the message control word are writable, and only through byte lane 3 of the first capability dword. All other bits of that dword are unchanged by any write.
- R4: The second capability dword reads as the table offset (0) OR'd with the BAR index. It ignores writes.
- R5: The third capability dword reads as the pending-array offset 0x800 OR'd with the BAR index. It ignores writes.
- R6: Each byte lane is handled independently. A read returns the addressed bytes in little-endian lane order (lane n = bits 8n+7:8n) and returns zero in lanes whose byte enable is low.
- R7: A write that changes the function mask from 1 to 0 raises rescan_req_o for exactly one cycle. The pulse appears in the cycle right after the write's clock edge.
- R8: A write that changes enable from 0 to 1 while the resulting function mask is 0 raises the same one-cycle rescan pulse.
- R9: Writes that set the mask, clear enable, rewrite the current values, or set enable together with the mask produce no rescan pulse.
- R10: After reset, enable, function mask and rescan_req_o are all 0.
- R11: An access whose dword address lies outside the capability leaves cap_hit_o low and changes no state. cap_rdata_o is zero whenever there is no read hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_addr | input | ADDR_W | Configuration dword address |
| cfg_be | input | 4 | Byte enables, lane n = bits 8n+7:8n |
| cfg_wr | input | 1 | Write strobe, one cycle per write |
| cfg_rd | input | 1 | Read strobe |
| cfg_wdata | input | 32 | Write data |
| cap_hit_o | output | 1 | Address falls inside the capability |
| cap_rdata_o | output | 32 | Read data, combinational, zero without a read hit |
| vec_enable_o | output | 1 | Global MSI-X enable |
| func_mask_o | output | 1 | Function-wide mask |
| rescan_req_o | output | 1 | One-cycle request to rescan pending vectors |

## Verification
The assertions assume that a read and a write never share a cycle. They also assume that cfg_wr and cfg_rd are clean single-cycle strobes sampled at the rising clock edge. The rescan properties use only the port values of enable and mask, so they rely on those ports changing only through a capability write. The stimulus keeps to these rules: it issues exactly one operation per strobe cycle, drives the strobes low between operations, and draws its random addresses mostly from the capability dwords and their immediate neighbours.

// File: rtl/msix_cap_pkg.sv
package msix_cap_pkg;

   localparam logic [7:0] MSIX_CAP_ID  = 8'h11;
   localparam int         CAP_DWORDS   = 3;
   localparam int         TSZ_W        = 11;
   localparam int         MAX_VECTORS  = 2048;
   localparam int         ENABLE_BIT   = 31;
   localparam int         FMASK_BIT    = 30;
   // bits software may change inside the header dword
   localparam logic [31:0] HDR_WMASK   = 32'hC000_0000;

   typedef enum logic [1:0] {
      CAP_DW_HDR  = 2'd0,
      CAP_DW_TBL  = 2'd1,
      CAP_DW_PBA  = 2'd2,
      CAP_DW_NONE = 2'd3
   } cap_dw_e;

   typedef struct packed {
      logic enable;
      logic fmask;
   } msix_ctrl_t;

   // a rescan is needed when the write may have released held vectors
   function automatic logic rescan_needed(msix_ctrl_t old_s, msix_ctrl_t new_s);
      return (old_s.fmask && !new_s.fmask) ||
             (!old_s.enable && new_s.enable && !new_s.fmask);
   endfunction

endpackage

// File: rtl/msix_cap_decode.sv
module msix_cap_decode
   import msix_cap_pkg::*;
#(
   parameter int ADDR_W     = 10,
   parameter int CAP_OFFSET = 176
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output cap_dw_e           sel
);
   localparam int                BASE_DW = CAP_OFFSET / 4;
   localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(BASE_DW);
   localparam logic [ADDR_W-1:0] SPAN_A  = ADDR_W'(CAP_DWORDS);

   logic [ADDR_W-1:0] rel;

   always_comb begin
      rel = addr - BASE_A;
      hit = (addr >= BASE_A) && (rel < SPAN_A);
      sel = CAP_DW_NONE;
      if (hit) begin
         sel = cap_dw_e'(rel[1:0]);
      end
   end
endmodule

// File: rtl/msix_cap_wfilter.sv
module msix_cap_wfilter
   import msix_cap_pkg::*;
(
   input  logic        wr,
   input  logic        hit,
   input  cap_dw_e     sel,
   input  logic [3:0]  be,
   input  logic [31:0] wdata,
   input  msix_ctrl_t  cur,
   output logic        we,
   output msix_ctrl_t  nxt
);
   logic [3:0]  lane_we;
   logic [31:0] lane_mask;
   logic [31:0] cur_dw;
   logic [31:0] merged;
   logic        unused_merged;

   for (genvar l = 0; l < 4; l++) begin : g_lane
      localparam logic [7:0] LM = HDR_WMASK[8*l +: 8];
      if (LM != 8'h00) begin : g_rw
         assign lane_we[l] = wr && hit && (sel == CAP_DW_HDR) && be[l];
      end else begin : g_ro
         assign lane_we[l] = 1'b0;
      end
      assign lane_mask[8*l +: 8] = lane_we[l] ? LM : 8'h00;
   end

   always_comb begin
      cur_dw               = '0;
      cur_dw[ENABLE_BIT]   = cur.enable;
      cur_dw[FMASK_BIT]    = cur.fmask;
      merged               = (wdata & lane_mask) | (cur_dw & ~lane_mask);
      we                   = |lane_we;
      nxt.enable           = merged[ENABLE_BIT];
      nxt.fmask            = merged[FMASK_BIT];
   end

   assign unused_merged = ^merged[29:0];
endmodule

// File: rtl/msix_cap_ctrl.sv
module msix_cap_ctrl
   import msix_cap_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we,
   input  msix_ctrl_t nxt,
   output msix_ctrl_t state,
   output logic       rescan
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= '0;
         rescan <= 1'b0;
      end else begin
         rescan <= we && rescan_needed(state, nxt);
         if (we) begin
            state <= nxt;
         end
      end
   end
endmodule

// File: rtl/msix_cap_rdmux.sv
module msix_cap_rdmux
   import msix_cap_pkg::*;
#(
   parameter int         NUM_VECTORS  = 64,
   parameter logic [7:0] NEXT_PTR     = 8'h70,
   parameter int         BAR_INDEX    = 2,
   parameter int         TABLE_OFFSET = 0,
   parameter int         PBA_OFFSET   = 2048
) (
   input  logic        rd,
   input  logic        hit,
   input  cap_dw_e     sel,
   input  logic [3:0]  be,
   input  msix_ctrl_t  st,
   output logic [31:0] rdata
);
   localparam logic [TSZ_W-1:0] TSZ_FIELD = TSZ_W'(NUM_VECTORS - 1);
   localparam logic [31:0] TBL_DW = 32'(TABLE_OFFSET) | 32'(BAR_INDEX);
   localparam logic [31:0] PBA_DW = 32'(PBA_OFFSET)   | 32'(BAR_INDEX);

   logic [15:0] msgctl;
   logic [31:0] dw;

   always_comb begin
      msgctl = {st.enable, st.fmask, 3'b000, TSZ_FIELD};
      case (sel)
         CAP_DW_HDR: dw = {msgctl, NEXT_PTR, MSIX_CAP_ID};
         CAP_DW_TBL: dw = TBL_DW;
         CAP_DW_PBA: dw = PBA_DW;
         default:    dw = '0;
      endcase
   end

   for (genvar l = 0; l < 4; l++) begin : g_lane
      assign rdata[8*l +: 8] = (rd && hit && be[l]) ? dw[8*l +: 8] : 8'h00;
   end
endmodule

// File: rtl/msix_cap_regs.sv
module msix_cap_regs
   import msix_cap_pkg::*;
#(
   parameter int         ADDR_W       = 10,
   parameter int         CAP_OFFSET   = 176,
   parameter int         NUM_VECTORS  = 64,
   parameter logic [7:0] NEXT_PTR     = 8'h70,
   parameter int         BAR_INDEX    = 2,
   parameter int         TABLE_OFFSET = 0,
   parameter int         PBA_OFFSET   = 2048
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [3:0]        cfg_be,
   input  logic              cfg_wr,
   input  logic              cfg_rd,
   input  logic [31:0]       cfg_wdata,
   output logic              cap_hit_o,
   output logic [31:0]       cap_rdata_o,
   output logic              vec_enable_o,
   output logic              func_mask_o,
   output logic              rescan_req_o
);
   // elaboration-time legality checks
   if (BAR_INDEX < 0 || BAR_INDEX > 5) begin : g_bad_bar
      $error("msix_cap_regs: BAR_INDEX must lie in 0..5");
   end
   if (NUM_VECTORS < 1 || NUM_VECTORS > MAX_VECTORS) begin : g_bad_vec
      $error("msix_cap_regs: NUM_VECTORS must lie in 1..2048");
   end
   if ((CAP_OFFSET % 4) != 0 || CAP_OFFSET < 64 ||
       (CAP_OFFSET / 4 + CAP_DWORDS) > (1 << ADDR_W)) begin : g_bad_off
      $error("msix_cap_regs: CAP_OFFSET must be dword aligned and inside config space");
   end
   if ((TABLE_OFFSET % 8) != 0 || (PBA_OFFSET % 8) != 0) begin : g_bad_align
      $error("msix_cap_regs: table and pending offsets must be 8-byte aligned");
   end

   logic       hit;
   cap_dw_e    sel;
   logic       ctl_we;
   msix_ctrl_t ctl_nxt;
   msix_ctrl_t ctl_q;
   logic       rescan;

   msix_cap_decode #(
      .ADDR_W    (ADDR_W),
      .CAP_OFFSET(CAP_OFFSET)
   ) u_decode (
      .addr(cfg_addr),
      .hit (hit),
      .sel (sel)
   );

   msix_cap_wfilter u_wfilter (
      .wr   (cfg_wr),
      .hit  (hit),
      .sel  (sel),
      .be   (cfg_be),
      .wdata(cfg_wdata),
      .cur  (ctl_q),
      .we   (ctl_we),
      .nxt  (ctl_nxt)
   );

   msix_cap_ctrl u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (ctl_we),
      .nxt   (ctl_nxt),
      .state (ctl_q),
      .rescan(rescan)
   );

   msix_cap_rdmux #(
      .NUM_VECTORS (NUM_VECTORS),
      .NEXT_PTR    (NEXT_PTR),
      .BAR_INDEX   (BAR_INDEX),
      .TABLE_OFFSET(TABLE_OFFSET),
      .PBA_OFFSET  (PBA_OFFSET)
   ) u_rdmux (
      .rd   (cfg_rd),
      .hit  (hit),
      .sel  (sel),
      .be   (cfg_be),
      .st   (ctl_q),
      .rdata(cap_rdata_o)
   );

   assign cap_hit_o    = hit;
   assign vec_enable_o = ctl_q.enable;
   assign func_mask_o  = ctl_q.fmask;
   assign rescan_req_o = rescan;
endmodule

// File: rtl/msix_cap_checker.sv
module msix_cap_checker #(
   parameter int         ADDR_W     = 10,
   parameter int         CAP_OFFSET = 176,
   parameter logic [7:0] NEXT_PTR   = 8'h70
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] cfg_addr,
   input logic [3:0]        cfg_be,
   input logic              cfg_wr,
   input logic              cfg_rd,
   input logic [31:0]       cap_rdata_o,
   input logic              vec_enable_o,
   input logic              func_mask_o,
   input logic              rescan_req_o
);
   localparam logic [ADDR_W-1:0] HDR_A = ADDR_W'(CAP_OFFSET / 4);

   assert_id_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd && cfg_addr == HDR_A && cfg_be[0]) |-> cap_rdata_o[7:0] == 8'h11);

   assert_next_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd && cfg_addr == HDR_A && cfg_be[1]) |-> cap_rdata_o[15:8] == NEXT_PTR);

   assert_ctl_needs_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({vec_enable_o, func_mask_o}) |->
         $past(cfg_wr && cfg_addr == HDR_A && cfg_be[3]));

   assert_mask_fall_pulses_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(func_mask_o) |-> rescan_req_o);

   assert_enable_rise_pulses_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(vec_enable_o) && !func_mask_o) |-> rescan_req_o);

   assert_pulse_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rescan_req_o |-> ($fell(func_mask_o) || ($rose(vec_enable_o) && !func_mask_o)));
endmodule

bind msix_cap_regs msix_cap_checker #(
   .ADDR_W    (ADDR_W),
   .CAP_OFFSET(CAP_OFFSET),
   .NEXT_PTR  (NEXT_PTR)
) u_msix_cap_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_addr    (cfg_addr),
   .cfg_be      (cfg_be),
   .cfg_wr      (cfg_wr),
   .cfg_rd      (cfg_rd),
   .cap_rdata_o (cap_rdata_o),
   .vec_enable_o(vec_enable_o),
   .func_mask_o (func_mask_o),
   .rescan_req_o(rescan_req_o)
);

// File: tb/test_msix_cap_regs.sv
`timescale 1ns/1ps
module test_msix_cap_regs;
   localparam int         ADDR_W = 10;
   localparam int         CAPOFF = 176;
   localparam int         NVEC   = 64;
   localparam logic [7:0] NPTR   = 8'h70;
   localparam int         BAR    = 2;
   localparam logic [ADDR_W-1:0] BASE = ADDR_W'(CAPOFF / 4);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] cfg_addr = '0;
   logic [3:0]        cfg_be = '0;
   logic              cfg_wr = 1'b0;
   logic              cfg_rd = 1'b0;
   logic [31:0]       cfg_wdata = '0;
   logic              cap_hit_o;
   logic [31:0]       cap_rdata_o;
   logic              vec_enable_o;
   logic              func_mask_o;
   logic              rescan_req_o;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  m_en = 1'b0;
   bit  m_mask = 1'b0;

   always #10 clk = ~clk;

   msix_cap_regs #(
      .ADDR_W(ADDR_W), .CAP_OFFSET(CAPOFF), .NUM_VECTORS(NVEC),
      .NEXT_PTR(NPTR), .BAR_INDEX(BAR)
   ) i_msix_cap_regs (
      .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
      .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_wdata(cfg_wdata),
      .cap_hit_o(cap_hit_o), .cap_rdata_o(cap_rdata_o),
      .vec_enable_o(vec_enable_o), .func_mask_o(func_mask_o),
      .rescan_req_o(rescan_req_o)
   );

   task automatic check(input bit ok, input string tag,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_dw(input logic [ADDR_W-1:0] a);
      logic [31:0] d;
      if (a == BASE)
         d = {m_en, m_mask, 3'b000, 11'(NVEC - 1), NPTR, 8'h11};
      else if (a == BASE + 1)
         d = 32'(BAR);
      else if (a == BASE + 2)
         d = 32'h800 | 32'(BAR);
      else
         d = '0;
      return d;
   endfunction

   function automatic logic [31:0] exp_rd(input logic [ADDR_W-1:0] a, input logic [3:0] be);
      logic [31:0] d = exp_dw(a);
      for (int l = 0; l < 4; l++) begin
         if (!be[l]) d[8*l +: 8] = 8'h00;
      end
      return d;
   endfunction

   task automatic do_op(input bit wr, input bit rd, input logic [ADDR_W-1:0] a,
                        input logic [3:0] be, input logic [31:0] d, input string tag);
      bit exp_hit, n_en, n_mask, exp_p;
      @(negedge clk);
      check(rescan_req_o == 1'b0, "R7 pulse width", {31'b0, rescan_req_o}, 32'h0);
      cfg_wr = wr; cfg_rd = rd; cfg_addr = a; cfg_be = be; cfg_wdata = d;
      #2;
      exp_hit = (a >= BASE) && (a < BASE + 3);
      check(cap_hit_o == exp_hit, "R11 hit", {31'b0, cap_hit_o}, {31'b0, exp_hit});
      if (rd)
         check(cap_rdata_o == exp_rd(a, be), tag, cap_rdata_o, exp_rd(a, be));
      else
         check(cap_rdata_o == 32'h0, "R11 idle rdata", cap_rdata_o, 32'h0);
      n_en = m_en; n_mask = m_mask;
      if (wr && a == BASE && be[3]) begin
         n_en = d[31]; n_mask = d[30];
      end
      exp_p = (m_mask && !n_mask) || (!m_en && n_en && !n_mask);
      @(negedge clk);
      cfg_wr = 1'b0; cfg_rd = 1'b0;
      check(rescan_req_o == exp_p, "R7 R8 R9 rescan", {31'b0, rescan_req_o}, {31'b0, exp_p});
      check({vec_enable_o, func_mask_o} == {n_en, n_mask}, "R3 R11 state",
            {30'b0, vec_enable_o, func_mask_o}, {30'b0, n_en, n_mask});
      m_en = n_en; m_mask = n_mask;
   endtask

   initial begin : watchdog
      #(200000 * 20);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      check({vec_enable_o, func_mask_o, rescan_req_o} == 3'b000, "R10 reset",
            {29'b0, vec_enable_o, func_mask_o, rescan_req_o}, 32'h0);
      // R1 R2 header read, 0x003F7011 with defaults
      do_op(0, 1, BASE, 4'hF, 0, "R1 R2 header");
      do_op(1, 0, BASE, 4'h7, 32'hFFFF_FFFF, "R1 R3 ro lanes");
      do_op(0, 1, BASE, 4'hF, 0, "R1 R2 after ro write");
      do_op(1, 0, BASE + 1, 4'hF, 32'hFFFF_FFFF, "R4 write");
      do_op(0, 1, BASE + 1, 4'hF, 0, "R4 table");
      do_op(1, 0, BASE + 2, 4'hF, 32'hFFFF_FFFF, "R5 write");
      do_op(0, 1, BASE + 2, 4'hF, 0, "R5 pba");
      do_op(0, 1, BASE, 4'b0100, 0, "R6 lane2 only");
      do_op(0, 1, BASE + 2, 4'b0010, 0, "R6 lane1 only");
      // rescan corner cases
      do_op(1, 0, BASE, 4'h8, 32'h4000_0000, "R9 set mask");
      do_op(1, 0, BASE, 4'h8, 32'h8000_0000, "R7 clear mask, set enable");
      do_op(1, 0, BASE, 4'h8, 32'h8000_0000, "R9 rewrite");
      do_op(1, 0, BASE, 4'h8, 32'h0000_0000, "R9 clear enable");
      do_op(1, 0, BASE, 4'h8, 32'hC000_0000, "R9 enable with mask");
      do_op(1, 0, BASE, 4'h8, 32'h8000_0000, "R7 unmask");
      do_op(1, 0, BASE, 4'h8, 32'h0000_0000, "R9 disable");
      do_op(1, 0, BASE, 4'h8, 32'h8000_0000, "R8 enable");
      do_op(1, 0, BASE, 4'h7, 32'h0000_0000, "R3 lane3 off");
      do_op(1, 0, BASE - 1, 4'hF, 32'h0000_0000, "R11 below");
      do_op(1, 0, BASE + 3, 4'hF, 32'h0000_0000, "R11 above");
      do_op(0, 1, BASE - 1, 4'hF, 0, "R11 read outside");
      do_op(0, 1, BASE, 4'hF, 0, "R2 header after writes");
      // constrained random mix
      for (int i = 0; i < 600; i++) begin
         logic [ADDR_W-1:0] a;
         logic [3:0]        be;
         logic [31:0]       d;
         bit                w;
         int                pick;
         pick = int'($urandom_range(0, 9));
         if (pick < 6)      a = BASE;
         else if (pick < 8) a = BASE + ADDR_W'($urandom_range(0, 3));
         else               a = ADDR_W'($urandom);
         be = 4'($urandom);
         d  = $urandom;
         w  = 1'($urandom);
         do_op(w, !w, a, be, d, "R6 R1 R4 R5 random read");
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule